// File: doc/BRIEF.md
# At-Speed Burst Test Clock Controller

This controller sequences the clock and scan enable of a scan or self-test pattern. After a start strobe it gives one slow shift pulse for each shift-rate strobe until the scan chains are full. It then switches to the fast functional clock for a burst of pulses. Scan enable stays high for all but the last pulse of the burst, so the chain contents rotate at speed and the supply can settle. The last pulse is the single capture edge, taken with scan enable low. A done flag then marks the end of the pattern. The results are shifted out by the load phase of the next pattern.

Three run-time inputs shape the burst: its total length, how many of its early shift pulses are slowed, and the spacing of those slowed pulses. A slowed pulse with spacing N is preceded by N-1 suppressed fast cycles. The last shift pulse and the capture pulse are never slowed, so the launch-to-capture interval is always one fast period. The gated clock is the fast clock ANDed with an enable. That enable is updated on the falling edge, so the output can only change while the fast clock is low.

Top module: `burst_clk_ctrl`

## Requirements
- R1: After reset, scan enable is high, done is low and the gated clock gives no pulses.
- R2: A start strobe in idle begins a load phase of exactly CHAIN_LEN gated pulses, one per shift-rate strobe. Each pulse lands on the fast edge that follows a cycle with the strobe high, and scan enable is high at every load pulse.
- R3: After the last load pulse comes a burst of L pulses: L-1 shift pulses with scan enable high, then one capture pulse. Scan enable is low for exactly the one fast cycle before the capture edge, and high again after it.
- R4: The burst length L is taken from the length input and clamped to the range 2 to MAX_BURST.
- R5: The first min(slow count, L-2) shift pulses of the burst are slowed. Each one follows the previous gated pulse by the spacing value in fast cycles. All later shift pulses and the capture pulse follow their predecessor by one fast cycle.
- R6: A spacing value of 0 or 1 gives no slowing, so every burst pulse is one fast cycle after the previous one.
- R7: Done is high for exactly one fast cycle, the cycle right after the capture edge, and scan enable is high in that cycle.
- R8: A start strobe outside idle has no effect. Shift-rate strobes have no effect in idle or during the burst.
- R9: The gated clock is low whenever the fast clock is low, and its enable changes only on the falling edge of the fast clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pattern (accepted in idle only) |
| shift_tick | input | 1 | Slow shift-rate strobe, one fast cycle wide |
| burst_len | input | BW | Requested burst length, clamped to 2..MAX_BURST |
| slow_cnt | input | BW | Number of burst shift pulses to slow |
| slow_gap | input | GAP_W | Spacing of slowed pulses in fast cycles (0 means 1) |
| tclk_o | output | 1 | Gated test clock |
| se_o | output | 1 | Scan enable (high = shift) |
| done_o | output | 1 | One-cycle end-of-pattern flag |

## Verification
The assertions watch several properties on every cycle. A falling scan enable is followed by done. A capture pulse taken with scan enable low leads to done. Done lasts one cycle, with scan enable high. Idle produces no pulses, and a load pulse only follows a shift-rate strobe. A started burst runs through to capture. The exact pulse spacing cannot be seen by these local properties: the slowed gaps, the run of fast pulses, the clamped length, and the fact that a stray start or strobe leaves the sequence unchanged. Only the bench scenarios show these, by comparing every recorded pulse position with a computed schedule.

// File: rtl/burst_clk_ctrl.sv
module burst_clk_ctrl #(
  parameter int CHAIN_LEN = 8,
  parameter int MAX_BURST = 16,
  parameter int GAP_W = 4,
  localparam int LW = $clog2(CHAIN_LEN + 1),
  localparam int BW = $clog2(MAX_BURST + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             shift_tick,
  input  logic [BW-1:0]    burst_len,
  input  logic [BW-1:0]    slow_cnt,
  input  logic [GAP_W-1:0] slow_gap,
  output logic             tclk_o,
  output logic             se_o,
  output logic             done_o
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_BURST, S_CAPT} st_t;

  st_t              st;
  logic [LW-1:0]    ld_left;
  logic [BW-1:0]    sh_left, slow_left, len_c, slow_c;
  logic [GAP_W-1:0] gap, gap_rel, gap_c;
  logic             fire, gate_q, se_q, done_q;

  assign len_c  = (burst_len < BW'(2)) ? BW'(2) :
                  (burst_len > BW'(MAX_BURST)) ? BW'(MAX_BURST) : burst_len;
  assign slow_c = (slow_cnt < len_c - BW'(2)) ? slow_cnt : len_c - BW'(2);
  assign gap_c  = (slow_gap == '0) ? GAP_W'(1) : slow_gap;

  always_comb begin
    case (st)
      S_LOAD:  fire = shift_tick;
      S_BURST: fire = (slow_left == '0) || (gap == GAP_W'(1));
      S_CAPT:  fire = 1'b1;
      default: fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ld_left   <= '0;
      sh_left   <= '0;
      slow_left <= '0;
      gap       <= '0;
      gap_rel   <= '0;
      se_q      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      se_q   <= 1'b1;
      done_q <= (st == S_CAPT);
      case (st)
        S_IDLE: if (start) begin
          st        <= S_LOAD;
          ld_left   <= LW'(CHAIN_LEN);
          sh_left   <= len_c - BW'(1);
          slow_left <= slow_c;
          gap_rel   <= gap_c;
          gap       <= gap_c;
        end
        S_LOAD: if (shift_tick) begin
          ld_left <= ld_left - LW'(1);
          if (ld_left == LW'(1)) st <= S_BURST;
        end
        S_BURST: begin
          if (fire) begin
            sh_left <= sh_left - BW'(1);
            if (slow_left != '0) begin
              slow_left <= slow_left - BW'(1);
              gap       <= gap_rel;
            end
            if (sh_left == BW'(1)) begin
              st   <= S_CAPT;
              se_q <= 1'b0;
            end
          end else begin
            gap <= gap - GAP_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= fire;
  end

  assign tclk_o = clk & gate_q;
  assign se_o   = se_q;
  assign done_o = done_q;

  AST_SE_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(se_o) |=> done_o);  // R3
  AST_CAPT_SE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && !se_o) |=> done_o);  // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7
  AST_DONE_SE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> se_o);  // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !gate_q);  // R8
  AST_LOAD_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOAD && !shift_tick) |-> !gate_q);  // R2
  AST_BURST_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST) |=> (st == S_BURST || st == S_CAPT));  // R8
  AST_GAP_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BURST && slow_left != '0) |-> (gap != '0));  // R5

endmodule

// File: tb/tb_burst_clk_ctrl.sv
module tb_burst_clk_ctrl;
  localparam int CLK_PER = 8;
  localparam int CHAIN = 8;
  localparam int MAXB = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, shift_tick = 1'b0;
  logic [4:0] burst_len = '0, slow_cnt = '0;
  logic [3:0] slow_gap = '0;
  logic tclk_o, se_o, done_o;
  int total = 0, bad = 0;

  burst_clk_ctrl #(.CHAIN_LEN(CHAIN), .MAX_BURST(MAXB), .GAP_W(4)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .shift_tick(shift_tick),
    .burst_len(burst_len), .slow_cnt(slow_cnt), .slow_gap(slow_gap),
    .tclk_o(tclk_o), .se_o(se_o), .done_o(done_o));

  always #(CLK_PER/2) clk = ~clk;

  task automatic chk(string r, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", r, got, exp);
    end
  endtask

  function automatic int clamp_len(int l);
    return (l < 2) ? 2 : (l > MAXB) ? MAXB : l;
  endfunction

  function automatic int n_slow(int l, int sc);
    return (sc < clamp_len(l) - 2) ? sc : clamp_len(l) - 2;
  endfunction

  task automatic run_case(int l, int sc, int n, int dv, bit poke);
    int ev[64];
    bit sb[64];
    int np = 0, dk = -1, dcnt = 0, selow = 0, selow_k = -1, glitch = 0;
    int lc, m, nc, e, capk;
    bit se_prev = 1'b1;
    lc = clamp_len(l);
    m  = n_slow(l, sc);
    nc = (n == 0) ? 1 : n;
    @(posedge clk); #(CLK_PER/4);
    burst_len = 5'(l); slow_cnt = 5'(sc); slow_gap = 4'(n); start = 1'b1;
    for (int k = 0; k < 4000; k++) begin
      @(posedge clk); #(CLK_PER/4);
      if (tclk_o && np < 64) begin ev[np] = k; sb[np] = se_prev; np++; end
      if (!se_o) begin selow++; selow_k = k; end
      if (done_o) begin dcnt++; if (dk < 0) dk = k; end
      se_prev = se_o;
      shift_tick = ((k % dv) == dv - 1);
      start = poke && (dk < 0);
      if (poke) burst_len = 5'($urandom_range(0, 31));
      #(CLK_PER/2);
      if (tclk_o) glitch++;
      if (dk >= 0 && k >= dk + 20) break;
    end
    start = 1'b0; shift_tick = 1'b0;
    chk("R7 done seen", (dk >= 0) ? 1 : 0, 1);
    chk("R7 done width", dcnt, 1);
    chk("R4 pulse count", np, CHAIN + lc);
    chk("R9 low-phase pulses", glitch, 0);
    if (np != CHAIN + lc || dk < 0) return;
    for (int i = 0; i < CHAIN; i++) begin
      chk("R2 load edge", ev[i], dv * (i + 1));
      chk("R2 load se", sb[i], 1);
    end
    e = ev[CHAIN-1];
    for (int j = 0; j < lc - 1; j++) begin
      e += (j < m) ? nc : 1;
      chk((j < m) ? ((n <= 1) ? "R6 slowed edge" : "R5 slowed edge") : "R5 fast edge",
          ev[CHAIN + j], e);
      chk("R3 shift se", sb[CHAIN + j], 1);
    end
    capk = e + 1;
    chk("R3 capture edge", ev[CHAIN + lc - 1], capk);
    chk("R3 capture se", sb[CHAIN + lc - 1], 0);
    chk("R3 se low cycles", selow, 1);
    chk("R3 se low position", selow_k, capk - 1);
    chk("R7 done position", dk, capk);
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int pulses = 0;
    seed = $urandom(32'd20240613);
    repeat (3) @(posedge clk);
    #(CLK_PER/4);
    chk("R1 reset se", se_o, 1);
    chk("R1 reset done", done_o, 0);
    chk("R1 reset clock", tclk_o, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #(CLK_PER/4);
      if (tclk_o || done_o || !se_o) pulses++;
      shift_tick = k[0];
    end
    shift_tick = 1'b0;
    chk("R8 idle ignores shift strobe", pulses, 0);
    run_case(5, 0, 1, 2, 1'b0);
    run_case(2, 3, 4, 3, 1'b0);
    run_case(0, 0, 5, 1, 1'b0);
    run_case(31, 31, 3, 2, 1'b0);
    run_case(16, 14, 15, 4, 1'b0);
    run_case(8, 3, 0, 2, 1'b0);
    run_case(8, 5, 1, 3, 1'b0);
    run_case(7, 2, 3, 2, 1'b1);
    for (int i = 0; i < 30; i++)
      run_case($urandom_range(0, 20), $urandom_range(0, 20), $urandom_range(0, 15),
               $urandom_range(1, 4), ($urandom_range(0, 3) == 0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule